// File: doc/BRIEF.md
# Bit-Split Multi-Pattern Match Engine with Per-Tile Vector Tables

This block scans a byte stream at one byte per clock against a set of up to `PATTERNS` strings, reporting every pattern that ends at each byte. The automaton is split across four small tiles. Each tile sees only two bits of every byte and walks its own state table. Each state row carries four next-state pointers, one per 2-bit slice value, and a short pointer into a separate table of partial match vectors in the same tile. A pattern has matched only when all four tiles agree on it, so the four partial vectors are combined with a bitwise AND into a full match vector that has one bit per pattern.

The vector tables are read through a registered stage after the state lookup. The reported vector therefore trails the byte that caused it by a fixed number of cycles. The state walk itself never waits for that read. A valid flag travels down a matching pipeline, so each reported vector lines up with exactly one accepted byte. A host port writes the state rows and vector entries of any tile. Table contents are produced offline. Vector pointer 0 is reserved to mean "no pattern ends here".

Top module: `bsm_match_engine`

## Requirements
- R1: Every byte accepted with `in_valid` high produces exactly one `mvec_valid` pulse 1+`VEC_LAT` clock edges later (2 with the default `VEC_LAT`=1). Back-to-back bytes are accepted every cycle with no stall.
- R2: Tile t (t = 0..3) forms its 2-bit slice as {byte bit 7−t, byte bit t}. The slice value k selects the next-state field at row bits [k·SW +: SW]. The vector pointer sits at row bits [4·SW +: VW], where SW = log2(STATES) and VW = log2(VECTORS).
- R3: While `in_valid` is low, no tile changes state, whatever `in_byte` carries.
- R4: The reported vector is the bitwise AND of the four tiles' vector-table entries. Each entry is addressed by the pointer stored in the row of the state that tile reached after the byte. Bit k set means pattern k ended at that byte.
- R5: A vector pointer of 0 yields an all-zero partial vector. Host writes to vector address 0 have no effect.
- R6: `mvec` is all zeros in every cycle where `mvec_valid` is low.
- R7: Synchronous active-low reset returns every tile to state 0 and clears the valid pipeline. Table contents are kept across reset and may be written while reset is asserted.
- R8: A host write (`cfg_we`, `cfg_sel` 0 = state row, 1 = vector entry, `cfg_tile`, `cfg_addr`, `cfg_data`) takes effect at the clock edge. A byte step or vector read at that same edge uses the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_byte` is to be consumed this cycle |
| in_byte | input | 8 | Stream byte |
| cfg_we | input | 1 | Host table write strobe |
| cfg_sel | input | 1 | 0 = state row table, 1 = partial vector table |
| cfg_tile | input | 2 | Target tile |
| cfg_addr | input | max(SW,VW) | Row or vector entry address (low bits used) |
| cfg_data | input | max(4·SW+VW, PATTERNS) | Row image, or vector in the low PATTERNS bits |
| mvec_valid | output | 1 | `mvec` belongs to an accepted byte |
| mvec | output | PATTERNS | Full match vector |

## Verification
The two functions that can fall in the same cycle are a host table write and a byte step that reads the very row or vector entry being written. The bench provokes this by writing, during a valid byte, the row that tile 2 currently occupies. On the next byte it writes the vector entry that tile 1 is about to read. A bench model that applies the read-before-write rule judges the result from the stream that follows: a tile that took the new row would diverge on the next byte and change the AND. Reset in mid-stream and the reserved null pointer are checked through the same model-driven comparison at every cycle.

// File: rtl/bsm_pkg.sv
// Shared constants, table selector type and slice helper for the bit-split
// match engine. Assumes a byte-wide input and four 2-bit tiles.
package bsm_pkg;

    localparam int unsigned TILE_CNT = 4;
    localparam int unsigned BRANCH   = 4;

    typedef enum logic {
        TBL_ROW = 1'b0,
        TBL_VEC = 1'b1
    } tbl_sel_e;

    // Pair bit t with its mirror bit 7-t; the mirror bit is the slice MSB.
    function automatic logic [1:0] tile_slice(input logic [7:0] b, input int unsigned t);
        return {b[7-t], b[t]};
    endfunction

endpackage

// File: rtl/bsm_state_tile.sv
// One bit-split tile: a state table of STATES rows, each holding BRANCH
// next-state pointers and a vector pointer, plus the current-state register.
// Assumes STATES is a power of two; rows are not reset (host loads them).
module bsm_state_tile
    import bsm_pkg::*;
#(
    parameter  int unsigned STATES = 16,
    parameter  int unsigned PTR_W  = 3,
    localparam int unsigned SW     = $clog2(STATES),
    localparam int unsigned RW     = BRANCH * SW + PTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [1:0]    slice,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_addr,
    input  logic [RW-1:0] wr_row,
    output logic [SW-1:0] state_o,
    output logic [PTR_W-1:0] vptr_o
);

    logic [RW-1:0] rows [STATES];
    logic [SW-1:0] cur_q;
    logic [RW-1:0] cur_row;
    logic [SW-1:0] nxt;

    // Row of the state the tile currently sits in.
    assign cur_row = rows[cur_q];
    assign nxt     = cur_row[int'(slice) * SW +: SW];
    assign vptr_o  = cur_row[BRANCH * SW +: PTR_W];
    assign state_o = cur_q;

    // Advance the walk on each accepted byte; reset returns to state 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (step) begin
            cur_q <= nxt;
        end
    end

    // Host write port for the state rows; kept across reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            rows[wr_addr] <= wr_row;
        end
    end

endmodule

// File: rtl/bsm_vec_table.sv
// Per-tile partial match vector table with a registered read and LAT total
// read stages (1 or 2). Entry 0 is reserved as the all-zero vector.
module bsm_vec_table #(
    parameter  int unsigned VECS  = 8,
    parameter  int unsigned PATS  = 8,
    parameter  int unsigned LAT   = 1,
    localparam int unsigned PTR_W = $clog2(VECS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [PATS-1:0]  wr_vec,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [PATS-1:0]  rd_vec_o,
    output logic [PATS-1:0]  al_vec_o
);

    logic [PATS-1:0] mem [VECS];
    logic [PATS-1:0] rd_q;

    // Host writes; the reserved null entry is never stored.
    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr != '0)) begin
            mem[wr_addr] <= wr_vec;
        end
    end

    // First read stage: null pointer forces zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= (rd_ptr == '0) ? '0 : mem[rd_ptr];
        end
    end

    assign rd_vec_o = rd_q;

    if (LAT > 1) begin : g_extra_stage
        logic [PATS-1:0] al_q;
        // Optional second stage to ease timing into the AND tree.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                al_q <= '0;
            end else begin
                al_q <= rd_q;
            end
        end
        assign al_vec_o = al_q;
    end else begin : g_single_stage
        assign al_vec_o = rd_q;
    end

endmodule

// File: rtl/bsm_match_engine.sv
// Bit-split multi-pattern matcher: four 2-bit tiles walk their state tables
// one byte per clock, each tile reads a partial vector through its own
// pointer-addressed table, and the aligned partial vectors are ANDed.
// Assumes tables are loaded by the host before meaningful matching.
module bsm_match_engine
    import bsm_pkg::*;
#(
    parameter  int unsigned STATES   = 16,
    parameter  int unsigned PATTERNS = 8,
    parameter  int unsigned VECTORS  = 8,
    parameter  int unsigned VEC_LAT  = 1,
    localparam int unsigned SW       = $clog2(STATES),
    localparam int unsigned VW       = $clog2(VECTORS),
    localparam int unsigned RW       = BRANCH * SW + VW,
    localparam int unsigned AW       = (SW > VW) ? SW : VW,
    localparam int unsigned DW       = (RW > PATTERNS) ? RW : PATTERNS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [7:0]          in_byte,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [1:0]          cfg_tile,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [DW-1:0]       cfg_data,
    output logic                mvec_valid,
    output logic [PATTERNS-1:0] mvec
);

    logic [TILE_CNT*SW-1:0]       state_flat;
    logic [TILE_CNT*VW-1:0]       vptr_flat;
    logic [TILE_CNT*PATTERNS-1:0] pmv_rd_flat;
    logic [TILE_CNT*PATTERNS-1:0] pmv_al_flat;
    logic [VEC_LAT:0]             vld_q;
    logic [PATTERNS-1:0]          and_acc;
    tbl_sel_e                     sel;

    assign sel = tbl_sel_e'(cfg_sel);

    for (genvar t = 0; t < TILE_CNT; t++) begin : g_tile
        localparam logic [1:0] TID = 2'(t);
        logic row_we;
        logic vec_we;

        assign row_we = cfg_we && (sel == TBL_ROW) && (cfg_tile == TID);
        assign vec_we = cfg_we && (sel == TBL_VEC) && (cfg_tile == TID);

        bsm_state_tile #(
            .STATES (STATES),
            .PTR_W  (VW)
        ) u_tile (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (in_valid),
            .slice   (tile_slice(in_byte, t)),
            .wr_en   (row_we),
            .wr_addr (cfg_addr[SW-1:0]),
            .wr_row  (cfg_data[RW-1:0]),
            .state_o (state_flat[t*SW +: SW]),
            .vptr_o  (vptr_flat[t*VW +: VW])
        );

        bsm_vec_table #(
            .VECS (VECTORS),
            .PATS (PATTERNS),
            .LAT  (VEC_LAT)
        ) u_vec (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (vec_we),
            .wr_addr  (cfg_addr[VW-1:0]),
            .wr_vec   (cfg_data[PATTERNS-1:0]),
            .rd_ptr   (vptr_flat[t*VW +: VW]),
            .rd_vec_o (pmv_rd_flat[t*PATTERNS +: PATTERNS]),
            .al_vec_o (pmv_al_flat[t*PATTERNS +: PATTERNS])
        );
    end

    // Valid flag pipeline matching the state step plus vector read stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[VEC_LAT-1:0], in_valid};
        end
    end

    assign mvec_valid = vld_q[VEC_LAT];

    // AND the aligned partial vectors of all tiles.
    always_comb begin
        and_acc = '1;
        for (int t = 0; t < TILE_CNT; t++) begin
            and_acc &= pmv_al_flat[t*PATTERNS +: PATTERNS];
        end
    end

    assign mvec = mvec_valid ? and_acc : '0;

endmodule

// File: rtl/bsm_match_engine_chk.sv
// Assertion checker for bsm_match_engine, attached by bind below. Watches
// the valid pipeline, tile states, pointers and partial vectors.
module bsm_match_engine_chk #(
    parameter int unsigned LAT = 1,
    parameter int unsigned SW  = 4,
    parameter int unsigned VW  = 3,
    parameter int unsigned PW  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [4*SW-1:0] state_flat,
    input logic [4*VW-1:0] vptr_flat,
    input logic [4*PW-1:0] pmv_rd_flat,
    input logic [4*PW-1:0] pmv_al_flat,
    input logic            mvec_valid,
    input logic [PW-1:0]   mvec
);

    logic [2:0] cyc;

    // Saturating count of clock edges since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 3'd7) begin
            cyc <= cyc + 3'd1;
        end
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'(LAT + 1)) |-> (mvec_valid == $past(in_valid, LAT + 1)));

    a_r3_idle_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state_flat));

    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> ((state_flat == '0) && !mvec_valid));

    for (genvar t = 0; t < 4; t++) begin : g_chk
        a_r5_null_pointer: assert property (@(posedge clk) disable iff (!rst_n)
            (vptr_flat[t*VW +: VW] == '0) |=> (pmv_rd_flat[t*PW +: PW] == '0));

        a_r4_subset_of_tile: assert property (@(posedge clk) disable iff (!rst_n)
            mvec_valid |-> ((mvec & ~pmv_al_flat[t*PW +: PW]) == '0));
    end

endmodule

bind bsm_match_engine bsm_match_engine_chk #(
    .LAT (VEC_LAT),
    .SW  (SW),
    .VW  (VW),
    .PW  (PATTERNS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .state_flat  (state_flat),
    .vptr_flat   (vptr_flat),
    .pmv_rd_flat (pmv_rd_flat),
    .pmv_al_flat (pmv_al_flat),
    .mvec_valid  (mvec_valid),
    .mvec        (mvec)
);

// File: tb/sim_bsm_match_engine.sv
`timescale 1ns/1ps
// Bench for bsm_match_engine: loads tables through the host port, walks a
// stimulus table, then runs directed collision, reset and null-pointer cases.
// A requirement-level model predicts every output cycle.
module sim_bsm_match_engine;

    localparam int S  = 16;
    localparam int P  = 8;
    localparam int V  = 8;
    localparam int SW = 4;
    localparam int VW = 3;
    localparam int RW = 4 * SW + VW;
    localparam int AW = 4;
    localparam int DW = RW;

    localparam logic [8:0] STIM [20] = '{
        9'h161, 9'h162, 9'h163, 9'h164, 9'h0FF, 9'h1A5, 9'h15A, 9'h000,
        9'h03C, 9'h1C3, 9'h181, 9'h118, 9'h1E7, 9'h07E, 9'h101, 9'h180,
        9'h17F, 9'h1FE, 9'h0AA, 9'h155
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [1:0]    cfg_tile = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_data = '0;
    logic          mvec_valid;
    logic [P-1:0]  mvec;

    int    n_run = 0;
    int    n_fail = 0;
    int    r5_hits = 0;
    logic  chk_en = 1'b0;
    logic  done = 1'b0;
    string tag = "R7";

    always #2 clk = ~clk;

    bsm_match_engine u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_byte (in_byte),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_tile (cfg_tile),
        .cfg_addr (cfg_addr), .cfg_data (cfg_data),
        .mvec_valid (mvec_valid), .mvec (mvec)
    );

    // Host-side model of tables, tile states and output pipeline.
    logic [RW-1:0] mrow [4][S];
    logic [P-1:0]  mvt  [4][V];
    logic [SW-1:0] mst  [4] = '{default: '0};
    logic          e1v = 1'b0;
    logic          e2v = 1'b0;
    logic [P-1:0]  e2vec = '0;

    always @(posedge clk) begin
        logic [P-1:0]  acc;
        logic [VW-1:0] p;
        logic [1:0]    sl;
        if (!rst_n) begin
            for (int t = 0; t < 4; t++) mst[t] <= '0;
            e1v   <= 1'b0;
            e2v   <= 1'b0;
            e2vec <= '0;
        end else begin
            acc = '1;
            for (int t = 0; t < 4; t++) begin
                p = mrow[t][mst[t]][4*SW +: VW];
                acc &= (p == '0) ? '0 : mvt[t][p];
            end
            e2vec <= acc;
            e2v   <= e1v;
            e1v   <= in_valid;
            if (in_valid) begin
                for (int t = 0; t < 4; t++) begin
                    sl = {in_byte[7-t], in_byte[t]};
                    mst[t] <= mrow[t][mst[t]][int'(sl)*SW +: SW];
                end
            end
        end
        if (cfg_we) begin
            if (!cfg_sel) mrow[cfg_tile][cfg_addr[SW-1:0]] <= cfg_data[RW-1:0];
            else if (cfg_addr[VW-1:0] != '0) mvt[cfg_tile][cfg_addr[VW-1:0]] <= cfg_data[P-1:0];
        end
    end

    // Per-cycle comparison of outputs against the model (R1 R4 R6 and phase tag).
    always @(negedge clk) begin
        logic [P-1:0] xm;
        if (chk_en) begin
            xm = e2v ? e2vec : '0;
            n_run++;
            if (mvec_valid !== e2v || mvec !== xm) begin
                n_fail++;
                $display("FAIL %s: valid=%0b vec=%h expected valid=%0b vec=%h",
                         tag, mvec_valid, mvec, e2v, xm);
            end
            if (tag == "R5" && mvec_valid && mvec == '0) r5_hits++;
        end
    end

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] mk_row(input int t, input int s);
        logic [RW-1:0] r;
        for (int k = 0; k < 4; k++) r[k*SW +: SW] = SW'((s * 5 + k * 3 + t + 1) % S);
        r[4*SW +: VW] = VW'((s + t) % V);
        return r;
    endfunction

    function automatic logic [P-1:0] mk_vec(input int t, input int a);
        return ~((P'(1) << ((a + t) % P)) | (P'(1) << ((a * 3 + t + 2) % P)));
    endfunction

    task automatic host_wr(input logic sel, input int t, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_tile = 2'(t); cfg_addr = AW'(a); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic v, input logic [7:0] b);
        @(negedge clk);
        in_valid = v; in_byte = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send(1'b0, 8'h00);
    endtask

    initial begin
        // Tables loaded while reset is held (R7), with a write to null entry (R5).
        for (int t = 0; t < 4; t++) begin
            for (int s = 0; s < S; s++) host_wr(1'b0, t, s, mk_row(t, s));
            for (int a = 0; a < V; a++) host_wr(1'b1, t, a, (a == 0) ? DW'({P{1'b1}}) : DW'(mk_vec(t, a)));
        end
        check("R7", mvec_valid == 1'b0, int'(mvec_valid), 0);
        check("R7", mvec == '0, int'(mvec), 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;

        // Stimulus table walk with bubbles carrying junk bytes.
        tag = "R1 R2 R3 R4 R6 stream";
        for (int i = 0; i < 20; i++) send(STIM[i][8], STIM[i][7:0]);
        for (int i = 0; i < 12; i++) send(1'b1, 8'(i * 37 + 11));
        idle(3);

        // Host write colliding with the byte step that reads the same row (R8).
        tag = "R8 collision";
        send(1'b1, 8'h21);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h5A;
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_tile = 2'd2;
        cfg_addr = AW'(mst[2]); cfg_data = {3'd5, 16'hFFFF};
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h33;
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_tile = 2'd1;
        cfg_addr = AW'(mrow[1][mst[1]][4*SW +: VW]); cfg_data = DW'(8'h0F);
        @(negedge clk);
        cfg_we = 1'b0;
        in_valid = 1'b1; in_byte = 8'h9C;
        for (int i = 0; i < 5; i++) send(1'b1, 8'(i * 53 + 7));
        idle(3);

        // Reset in the middle of a burst: pipeline cleared, tables kept (R7).
        tag = "R7 midstream";
        for (int i = 0; i < 3; i++) send(1'b1, 8'(i * 19 + 3));
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; in_byte = 8'hE1;
        @(negedge clk);
        check("R7", mvec_valid == 1'b0, int'(mvec_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) send(1'b1, STIM[i][7:0]);
        idle(3);

        // Null pointer: tile 3 pinned to state 0 whose pointer is 0 (R5).
        host_wr(1'b0, 3, 0, '0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R5";
        for (int i = 0; i < 6; i++) send(1'b1, 8'(i * 29 + 5));
        idle(3);
        tag = "R5 done";
        check("R5", r5_hits == 6, r5_hits, 6);

        chk_en = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1: watchdog expired, actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule